// File: doc/BRIEF.md
# Phase-Continuous FSK Transmit Modulator

This block turns a serial NRZ data bit into a binary FSK tone for a 1200 bit/s half-duplex field-bus link. A high data bit selects a 1200 Hz tone and a low data bit selects a 2200 Hz tone. The block runs from a 460.8 kHz clock. A 24-bit fractional phase accumulator produces both tones. This is needed because 2200 Hz is not an integer fraction of the clock. Switching tones only changes the accumulator step, so the waveform never jumps in phase at a bit boundary.

The accumulator phase drives a trapezoid shaper. The shaper outputs an 8-bit unsigned sample word for an external DAC, with mid-scale at 128. Linear ramps replace hard square edges. While the active-low request-to-send input is high, the transmitter is idle. In that state the accumulator is held at zero and the sample rests at mid-scale, so every burst starts at phase zero.

Top module: `fsk_tx_modulator`

## Requirements
- R1: Each clock while request-to-send is low, the 24-bit phase accumulator advances by a step chosen by the data bit: 43690 when the bit is 1 (1200 Hz) and 80100 when the bit is 0 (2200 Hz). The accumulator wraps modulo 2^24.
- R2: A change of data bit does not clear or reload the accumulator. While transmitting, consecutive sample words differ by at most 10 codes.
- R3: While request-to-send is high, the accumulator is zero and the sample word is 128, whatever the data bit.
- R4: The first sample word after request-to-send falls is 128 (phase zero). For a 1 bit, the next sample word is above 128.
- R5: Let p be accumulator bits [23:14], s = (p + 64) mod 1024, h = s[9] and q = s[8:0]. The sample is then:
  - 2q when h=0 and q<128;
  - 255 when h=0 and q>=128;
  - 255-2q when h=1 and q<128;
  - 0 otherwise.
- R6: The sample word is registered. It reflects the accumulator value and request-to-send level as they stood before the active clock edge, and it changes only at that edge.
- R7: A low reset input forces the sample word to 128 at once and clears the accumulator. Release passes through a two-stage synchronizer, so the first transmitting edge is the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 460.8 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_n | input | 1 | Active-low request-to-send; low enables transmission |
| txd | input | 1 | NRZ transmit data bit (1 = 1200 Hz, 0 = 2200 Hz) |
| sample | output | 8 | Unsigned DAC sample word, 128 = mid-scale |

## Verification
The table drives several input patterns:
- long runs of each tone from a cold start, which separate the two step sizes;
- a tone change mid-cycle and rapid toggles a few clocks apart, which expose any phase reset or discontinuity at a bit change;
- idle stretches with both data values, which show the data bit has no effect while idle;
- a stop and restart of request-to-send, which separates a cleared phase from a retained one.

Directed cases then pin down the one-clock output latency and the restart sample. They also pin down the exact edge on which reset release takes effect.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  typedef enum logic {
    TONE_SPACE = 1'b0,
    TONE_MARK  = 1'b1
  } tone_e;

  localparam int unsigned DFLT_ACC_W    = 24;
  localparam int unsigned DFLT_SAMPLE_W = 8;

endpackage

// File: rtl/fsk_rst_sync.sv
module fsk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
  import fsk_pkg::*;
#(
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned INC_MARK  = 43690,
  parameter int unsigned INC_SPACE = 80100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  tone_e            tone,
  output logic [ACC_W-1:0] acc
);

  localparam logic [ACC_W-1:0] STEP_MARK  = ACC_W'(INC_MARK);
  localparam logic [ACC_W-1:0] STEP_SPACE = ACC_W'(INC_SPACE);

  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    step  = (tone == TONE_MARK) ? STEP_MARK : STEP_SPACE;
    acc_d = run ? (acc + step) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end

endmodule

// File: rtl/fsk_trap_shaper.sv
module fsk_trap_shaper #(
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned SHP_W     = 10,
  parameter int unsigned RAMP_LOG2 = 7,
  parameter int unsigned SAMPLE_W  = 8
) (
  input  logic [ACC_W-1:0]    phase,
  output logic [SAMPLE_W-1:0] level
);

  localparam int unsigned HALF_W = SHP_W - 1;
  localparam logic [SHP_W-1:0] SKEW = SHP_W'(1) << (RAMP_LOG2 - 1);

  logic [SHP_W-1:0]    sp;
  logic [HALF_W-1:0]   q;
  logic [SAMPLE_W-1:0] ramp;
  logic                in_ramp;

  always_comb begin
    sp      = phase[ACC_W-1 -: SHP_W] + SKEW;
    q       = sp[HALF_W-1:0];
    ramp    = SAMPLE_W'(q[RAMP_LOG2-1:0]) << (SAMPLE_W - RAMP_LOG2);
    in_ramp = (q >> RAMP_LOG2) == '0;
    if (!sp[HALF_W]) level = in_ramp ? ramp  : '1;
    else             level = in_ramp ? ~ramp : '0;
  end

endmodule

// File: rtl/fsk_out_stage.sv
module fsk_out_stage #(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle,
  input  logic [SAMPLE_W-1:0] level,
  output logic [SAMPLE_W-1:0] sample
);

  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] sample_d;

  always_comb begin
    sample_d = idle ? MID : level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample <= MID;
    else        sample <= sample_d;
  end

endmodule

// File: rtl/fsk_tx_modulator.sv
module fsk_tx_modulator
  import fsk_pkg::*;
#(
  parameter int unsigned ACC_W     = DFLT_ACC_W,
  parameter int unsigned SAMPLE_W  = DFLT_SAMPLE_W,
  parameter int unsigned SHP_W     = 10,
  parameter int unsigned RAMP_LOG2 = 7,
  parameter int unsigned INC_MARK  = 43690,
  parameter int unsigned INC_SPACE = 80100,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rts_n,
  input  logic                txd,
  output logic [SAMPLE_W-1:0] sample
);

  logic             rst_sync_n;
  logic [ACC_W-1:0] acc;
  logic [SAMPLE_W-1:0] level;
  tone_e            tone;
  logic             run;

  assign tone = tone_e'(txd);
  assign run  = ~rts_n;

  fsk_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsk_phase_acc #(
    .ACC_W     (ACC_W),
    .INC_MARK  (INC_MARK),
    .INC_SPACE (INC_SPACE)
  ) u_phase_acc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tone  (tone),
    .acc   (acc)
  );

  fsk_trap_shaper #(
    .ACC_W     (ACC_W),
    .SHP_W     (SHP_W),
    .RAMP_LOG2 (RAMP_LOG2),
    .SAMPLE_W  (SAMPLE_W)
  ) u_shaper (
    .phase (acc),
    .level (level)
  );

  fsk_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idle   (rts_n),
    .level  (level),
    .sample (sample)
  );

endmodule

// File: rtl/fsk_tx_modulator_chk.sv
module fsk_tx_modulator_chk #(
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned SHP_W     = 10,
  parameter int unsigned RAMP_LOG2 = 7,
  parameter int unsigned INC_MARK  = 43690,
  parameter int unsigned INC_SPACE = 80100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rts_n,
  input logic                txd,
  input logic [ACC_W-1:0]    acc,
  input logic [SAMPLE_W-1:0] sample
);

  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);
  localparam int unsigned MAX_STEP =
    ((INC_SPACE >> (ACC_W - SHP_W)) + 1) << (SAMPLE_W - RAMP_LOG2);
  localparam logic [ACC_W-1:0] STEP_MARK  = ACC_W'(INC_MARK);
  localparam logic [ACC_W-1:0] STEP_SPACE = ACC_W'(INC_SPACE);

  assert_step_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rts_n)) |->
      (acc == $past(acc) + ($past(txd) ? STEP_MARK : STEP_SPACE)));

  assert_bounded_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rts_n) && !rts_n) |=>
      (((sample >= $past(sample)) ? (sample - $past(sample))
                                  : ($past(sample) - sample)) <= SAMPLE_W'(MAX_STEP)));

  assert_idle_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_n)) |-> (acc == '0 && sample == MID));

  assert_start_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(rts_n)) |=> (sample == MID));

endmodule

bind fsk_tx_modulator fsk_tx_modulator_chk #(
  .ACC_W     (ACC_W),
  .SAMPLE_W  (SAMPLE_W),
  .SHP_W     (SHP_W),
  .RAMP_LOG2 (RAMP_LOG2),
  .INC_MARK  (INC_MARK),
  .INC_SPACE (INC_SPACE)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .rts_n  (rts_n),
  .txd    (txd),
  .acc    (acc),
  .sample (sample)
);

// File: tb/fsk_tx_modulator_bench.sv
module fsk_tx_modulator_bench;

  localparam time CLK_PERIOD = 2170ns;
  localparam int  NSEG = 9;

  // segment: {rts_n, txd, cycles[11:0]}
  localparam logic [13:0] SEGS [NSEG] = '{
    {1'b1, 1'b0, 12'd20},
    {1'b1, 1'b1, 12'd20},
    {1'b0, 1'b1, 12'd384},
    {1'b0, 1'b0, 12'd384},
    {1'b0, 1'b1, 12'd7},
    {1'b0, 1'b0, 12'd3},
    {1'b0, 1'b1, 12'd384},
    {1'b1, 1'b1, 12'd10},
    {1'b0, 1'b0, 12'd500}
  };

  logic       clk;
  logic       rst_n;
  logic       rts_n;
  logic       txd;
  logic [7:0] sample;

  int n_chk;
  int n_bad;
  logic [23:0] acc_m;
  logic [7:0]  prev_s;
  logic        prev_run;

  fsk_tx_modulator u_fsk_tx_modulator (
    .clk    (clk),
    .rst_n  (rst_n),
    .rts_n  (rts_n),
    .txd    (txd),
    .sample (sample)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] shape_ref(input logic [23:0] a);
    int pos;
    pos = ((int'(a) / 16384) + 64) % 1024;
    if (pos < 128)      return 8'(2 * pos);
    else if (pos < 512) return 8'd255;
    else if (pos < 640) return 8'(255 - 2 * (pos - 512));
    else                return 8'd0;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sample=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_true(input logic cond, input int act, input int exp, input string tag);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, run one edge, compare at the next negedge
  task automatic step(input logic r, input logic d, input string tag);
    logic [7:0] exp;
    int diff;
    rts_n = r;
    txd   = d;
    exp   = r ? 8'd128 : shape_ref(acc_m);
    acc_m = r ? 24'd0 : acc_m + (d ? 24'd43690 : 24'd80100);
    @(negedge clk);
    chk(sample, exp, tag);
    if (!r && prev_run) begin
      diff = (sample >= prev_s) ? int'(sample - prev_s) : int'(prev_s - sample);
      chk_true(diff <= 10, diff, 10, "R2 step bound");
    end
    prev_s   = sample;
    prev_run = !r;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    n_chk = 0; n_bad = 0;
    acc_m = '0; prev_s = 8'd128; prev_run = 1'b0;
    rst_n = 1'b0; rts_n = 1'b1; txd = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample, 8'd128, "R7 reset state");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R3 idle after reset");

    // table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int c = 0; c < int'(SEGS[s][11:0]); c++) begin
        if (SEGS[s][13]) step(1'b1, SEGS[s][12], "R3 idle rest");
        else if (SEGS[s][12]) step(1'b0, 1'b1, "R1/R5 mark tone");
        else step(1'b0, 1'b0, "R1/R5 space tone");
      end
    end

    // R4: restart from idle begins at phase zero and rises for a mark
    step(1'b1, 1'b0, "R3 idle before restart");
    step(1'b0, 1'b1, "R4 restart");
    chk(sample, 8'd128, "R4 first sample mid");
    step(1'b0, 1'b1, "R4 second sample");
    chk_true(sample > 8'd128, sample, 129, "R4 rising start");
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, "R1/R5 mark run");

    // R6: output changes only at the edge
    hold  = sample;
    rts_n = 1'b1;
    #(CLK_PERIOD/4);
    chk(sample, hold, "R6 held until edge");
    acc_m = '0;
    @(negedge clk);
    chk(sample, 8'd128, "R6 idle after one edge");
    prev_run = 1'b0;

    // R7: asynchronous reset mid-run and synchronised release
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, "R1/R5 space run");
    rts_n = 1'b0; txd = 1'b0;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk(sample, 8'd128, "R7 async reset");
    @(negedge clk);
    txd = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample, 8'd128, "R7 sync edge 1");
    @(negedge clk);
    chk(sample, 8'd128, "R7 sync edge 2");
    @(negedge clk);
    chk(sample, 8'd128, "R7 first active edge");
    @(negedge clk);
    chk(sample, 8'd132, "R7 second active edge");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule